// File: doc/BRIEF.md
# External DMA Channel Controller

This block is one channel of direct memory access that an external device paces. The device pulls `drq_n` low to ask for a word. The channel runs the memory bus cycles for that word, pulses `dack_n` low for one cycle to acknowledge it, and pulls `done_n` low together with `dack_n` on the final word of the programmed block. When the block ends, the channel clears its own enable and raises a sticky interrupt, so software does not have to poll it.

There are two ways a word can move. In direct (fly-by) mode, memory and the device exchange the word over the shared data bus in one bus cycle, and the controller only supplies the address and the strobes. In buffered mode, the controller reads the word from a source address into a one-word holding register. In the next cycle it writes that word to a destination address, using a second chip select. Software sets the mode, the direction, both addresses and the word count through a small write/read register port before it sets the enable bit.

Top module: `edma_channel`

## Requirements
- R1: In direct mode each word takes exactly one bus cycle. During that cycle `mem_cs_n` is low, `mem_addr` holds the source register, and `dack_n` is low. `mem_rw` is 1 (read) when the direction bit selects transmit (memory to device) and 0 (write) when it selects receive.
- R2: In buffered mode each word is a read cycle followed at once by a write cycle. The read cycle has `mem_cs_n` low, `mem_rw`=1 and the source address. The write cycle has `mem_cs2_n` low, `mem_rw`=0, the destination address, and `mem_wdata` equal to the word read. `dack_n` is low only in the write cycle, and the two chip selects are never low together.
- R3: `drq_n` passes through a two-flop synchronizer. If rising edge E is the first edge to sample `drq_n` low while the channel is enabled and idle, the word's first bus cycle starts at edge E+2.
- R4: `dack_n` is low for exactly one cycle per word. After a word, no new word starts until the synchronized `drq_n` has been seen high, however long the device holds it low.
- R5: `done_n` is low only together with `dack_n`, and only on the last word of the block (count register equal to 1).
- R6: After every word the count register drops by 1. The source address rises by 4 in both modes. The destination address rises by 4 in buffered mode only.
- R7: In the cycle after the last word, the enable bit reads 0 and the interrupt bit and `irq` read 1. Holding `drq_n` low after that starts no bus cycle.
- R8: The interrupt bit is sticky. A control write with bit 3 set clears it, and a control write with bit 3 clear leaves it set.
- R9: While enable is 1, writes to the source, destination and count registers are ignored, and so are the enable, mode and direction fields of a control write. Only the interrupt clear acts.
- R10: Enabling with a count of 0 runs no bus cycle. One cycle later the enable bit reads 0 and the interrupt bit reads 1.
- R11: The holding register stores one word. It is loaded only in a read cycle, never while it is full, and emptied by the write cycle that follows.
- R12: Register map on `cfg_sel`: 0 = control, 1 = source, 2 = destination, 3 = count. The control bits are enable (bit 0), buffered mode (bit 1), transmit direction (bit 2) and interrupt (bit 3). Addresses are 28 bits and the count is 16 bits, read back zero-extended. After reset all registers read 0, `irq` is 0, and every active-low strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Block-complete interrupt (sticky) |
| drq_n | input | 1 | Active-low transfer request from the device |
| dack_n | output | 1 | Active-low per-word acknowledge |
| done_n | output | 1 | Active-low last-word marker |
| mem_addr | output | 28 | Memory address |
| mem_cs_n | output | 1 | Chip select for the source or direct-mode memory |
| mem_cs2_n | output | 1 | Chip select for the buffered-mode destination |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_wdata | output | 32 | Write data in the buffered write cycle |
| mem_rdata | input | 32 | Read data from memory |

## Verification
Two registers lie between a request and its first bus cycle. For a request driven after edge k, a direct-mode cycle or a buffered read appears after edge k+3, and the buffered write appears after edge k+4. The driver stamps each expected bus cycle with that exact cycle number when it raises the request. The monitor samples on the falling edge, matches every strobed cycle against the head of the queue, and treats a cycle that arrives early, late or without a queue entry as a failure. Register effects such as the enable clearing after the last word or after a zero-count enable are due one edge after the cause, and they are read through the register port on the next falling edge.

// File: rtl/edma_pkg.sv
package edma_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_FLY,
        SEQ_RD,
        SEQ_WR,
        SEQ_REL
    } seq_state_e;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_SRC   = 2'd1,
        REG_DST   = 2'd2,
        REG_COUNT = 2'd3
    } reg_sel_e;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_MODE_BIT = 1;
    localparam int unsigned CTRL_DIR_BIT  = 2;
    localparam int unsigned CTRL_IRQ_BIT  = 3;

    typedef struct packed {
        logic en;
        logic m2m;
        logic tx;
    } chan_mode_t;

endpackage

// File: rtl/edma_drq_sync.sv
module edma_drq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drq_n_i,
    output logic req_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES < 2) begin : g_single
            always_comb sync_d = drq_n_i;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], drq_n_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign req_o = ~sync_q[STAGES-1];

endmodule

// File: rtl/edma_hold_buf.sv
module edma_hold_buf #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              drain_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] word;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (load_i && !h_q.full) begin
            h_d.word = data_i;
            h_d.full = 1'b1;
        end
        if (drain_i) h_d.full = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign full_o = h_q.full;
    assign data_o = h_q.word;

    // R11
    hold_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !h_q.full);

    // R11
    hold_drain_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_i |-> h_q.full);

    // R11
    hold_load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (full_o && data_o == $past(data_i)));

endmodule

// File: rtl/edma_regs.sv
module edma_regs
    import edma_pkg::*;
#(
    parameter int unsigned ADDR_W    = 28,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned ADDR_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    input  logic              word_done_i,
    input  logic              seq_idle_i,
    output chan_mode_t        mode_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic              last_o,
    output logic              cnt_zero_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(ADDR_STEP);
    localparam logic [CNT_W-1:0]  ONE   = CNT_W'(1);

    typedef struct packed {
        logic              en;
        logic              m2m;
        logic              tx;
        logic              irq;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl, irq_clr;

    assign wr_ctrl = cfg_we_i && (cfg_sel_i == REG_CTRL);
    assign irq_clr = wr_ctrl && cfg_wdata_i[CTRL_IRQ_BIT];

    always_comb begin
        r_d = r_q;
        if (cfg_we_i && !r_q.en) begin
            case (reg_sel_e'(cfg_sel_i))
                REG_CTRL: begin
                    r_d.en  = cfg_wdata_i[CTRL_EN_BIT];
                    r_d.m2m = cfg_wdata_i[CTRL_MODE_BIT];
                    r_d.tx  = cfg_wdata_i[CTRL_DIR_BIT];
                end
                REG_SRC:   r_d.src = cfg_wdata_i[ADDR_W-1:0];
                REG_DST:   r_d.dst = cfg_wdata_i[ADDR_W-1:0];
                REG_COUNT: r_d.cnt = cfg_wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
        if (irq_clr) r_d.irq = 1'b0;
        if (word_done_i) begin
            r_d.cnt = r_q.cnt - ONE;
            r_d.src = r_q.src + STEP;
            if (r_q.m2m) r_d.dst = r_q.dst + STEP;
            if (r_q.cnt == ONE) begin
                r_d.en  = 1'b0;
                r_d.irq = 1'b1;
            end
        end else if (r_q.en && (r_q.cnt == '0) && seq_idle_i) begin
            r_d.en  = 1'b0;
            r_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        cfg_rdata_o = '0;
        case (reg_sel_e'(cfg_sel_i))
            REG_CTRL: begin
                cfg_rdata_o[CTRL_EN_BIT]   = r_q.en;
                cfg_rdata_o[CTRL_MODE_BIT] = r_q.m2m;
                cfg_rdata_o[CTRL_DIR_BIT]  = r_q.tx;
                cfg_rdata_o[CTRL_IRQ_BIT]  = r_q.irq;
            end
            REG_SRC:   cfg_rdata_o[ADDR_W-1:0] = r_q.src;
            REG_DST:   cfg_rdata_o[ADDR_W-1:0] = r_q.dst;
            REG_COUNT: cfg_rdata_o[CNT_W-1:0]  = r_q.cnt;
            default: ;
        endcase
    end

    assign mode_o     = '{en: r_q.en, m2m: r_q.m2m, tx: r_q.tx};
    assign src_o      = r_q.src;
    assign dst_o      = r_q.dst;
    assign last_o     = (r_q.cnt == ONE);
    assign cnt_zero_o = (r_q.cnt == '0);
    assign irq_o      = r_q.irq;

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done_i |=> (r_q.cnt == $past(r_q.cnt) - ONE));

    // R6
    src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done_i |=> (r_q.src == $past(r_q.src) + STEP));

    // R7
    block_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done_i && last_o) |=> (!r_q.en && irq_o));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr) |=> irq_o);

    // R9
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en && cfg_we_i && cfg_sel_i != REG_CTRL && !word_done_i)
        |=> ($stable(r_q.src) && $stable(r_q.dst) && $stable(r_q.cnt)));

    // R10
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en && cnt_zero_o && seq_idle_i) |=> (!r_q.en && irq_o));

endmodule

// File: rtl/edma_seq.sv
module edma_seq
    import edma_pkg::*;
#(
    parameter int unsigned ADDR_W = 28,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chan_mode_t        mode_i,
    input  logic              req_i,
    input  logic              cnt_zero_i,
    input  logic              last_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [DATA_W-1:0] buf_data_i,
    output logic              word_done_o,
    output logic              buf_load_o,
    output logic              buf_drain_o,
    output logic              idle_o,
    output logic              dack_n_o,
    output logic              done_n_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_cs_n_o,
    output logic              mem_cs2_n_o,
    output logic              mem_rw_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    typedef struct packed {
        seq_state_e state;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            SEQ_IDLE: if (mode_i.en && !cnt_zero_i && req_i)
                          s_d.state = mode_i.m2m ? SEQ_RD : SEQ_FLY;
            SEQ_FLY:  s_d.state = SEQ_REL;
            SEQ_RD:   s_d.state = SEQ_WR;
            SEQ_WR:   s_d.state = SEQ_REL;
            SEQ_REL:  if (!req_i) s_d.state = SEQ_IDLE;
            default:  s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: SEQ_IDLE};
        else        s_q <= s_d;
    end

    always_comb begin
        dack_n_o    = 1'b1;
        done_n_o    = 1'b1;
        mem_addr_o  = '0;
        mem_cs_n_o  = 1'b1;
        mem_cs2_n_o = 1'b1;
        mem_rw_o    = 1'b1;
        mem_wdata_o = '0;
        word_done_o = 1'b0;
        buf_load_o  = 1'b0;
        buf_drain_o = 1'b0;
        case (s_q.state)
            SEQ_FLY: begin
                mem_addr_o  = src_i;
                mem_cs_n_o  = 1'b0;
                mem_rw_o    = mode_i.tx;
                dack_n_o    = 1'b0;
                done_n_o    = ~last_i;
                word_done_o = 1'b1;
            end
            SEQ_RD: begin
                mem_addr_o  = src_i;
                mem_cs_n_o  = 1'b0;
                mem_rw_o    = 1'b1;
                buf_load_o  = 1'b1;
            end
            SEQ_WR: begin
                mem_addr_o  = dst_i;
                mem_cs2_n_o = 1'b0;
                mem_rw_o    = 1'b0;
                mem_wdata_o = buf_data_i;
                dack_n_o    = 1'b0;
                done_n_o    = ~last_i;
                word_done_o = 1'b1;
                buf_drain_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign idle_o = (s_q.state == SEQ_IDLE);

    // R4
    dack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dack_n_o |=> dack_n_o);

    // R4
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dack_n_o && req_i) |=> (mem_cs_n_o && mem_cs2_n_o));

    // R5
    done_with_dack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_n_o |-> !dack_n_o);

    // R2
    cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs2_n_o |-> mem_cs_n_o);

    // R2
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n_o && mode_i.m2m) |=> (!mem_cs2_n_o && !mem_rw_o));

endmodule

// File: rtl/edma_channel.sv
module edma_channel
    import edma_pkg::*;
#(
    parameter int unsigned ADDR_W      = 28,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              irq,
    input  logic              drq_n,
    output logic              dack_n,
    output logic              done_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs2_n,
    output logic              mem_rw,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    chan_mode_t        mode;
    logic              req, word_done, seq_idle, last, cnt_zero;
    logic              buf_load, buf_drain, buf_full;
    logic [ADDR_W-1:0] src, dst;
    logic [DATA_W-1:0] buf_data;

    edma_drq_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .drq_n_i (drq_n),
        .req_o   (req)
    );

    edma_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .ADDR_STEP (ADDR_STEP)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_sel_i   (cfg_sel),
        .cfg_wdata_i (cfg_wdata),
        .cfg_rdata_o (cfg_rdata),
        .word_done_i (word_done),
        .seq_idle_i  (seq_idle),
        .mode_o      (mode),
        .src_o       (src),
        .dst_o       (dst),
        .last_o      (last),
        .cnt_zero_o  (cnt_zero),
        .irq_o       (irq)
    );

    edma_hold_buf #(.DATA_W(DATA_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (buf_load),
        .data_i  (mem_rdata),
        .drain_i (buf_drain),
        .full_o  (buf_full),
        .data_o  (buf_data)
    );

    edma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .req_i       (req),
        .cnt_zero_i  (cnt_zero),
        .last_i      (last),
        .src_i       (src),
        .dst_i       (dst),
        .buf_data_i  (buf_data),
        .word_done_o (word_done),
        .buf_load_o  (buf_load),
        .buf_drain_o (buf_drain),
        .idle_o      (seq_idle),
        .dack_n_o    (dack_n),
        .done_n_o    (done_n),
        .mem_addr_o  (mem_addr),
        .mem_cs_n_o  (mem_cs_n),
        .mem_cs2_n_o (mem_cs2_n),
        .mem_rw_o    (mem_rw),
        .mem_wdata_o (mem_wdata)
    );

    // R11
    write_has_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs2_n |-> buf_full);

    // R3
    start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_cs_n) && seq_idle == 1'b0) |-> $past(req));

endmodule

// File: tb/test_edma_channel.sv
`timescale 1ns/1ps
module test_edma_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq;
    logic        drq_n = 1'b1;
    logic        dack_n, done_n;
    logic [27:0] mem_addr;
    logic        mem_cs_n, mem_cs2_n, mem_rw;
    logic [31:0] mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] memf(logic [27:0] a);
        return {4'hC, a} ^ 32'h3A5A_0F96;
    endfunction

    assign mem_rdata = memf(mem_addr);

    edma_channel i_edma_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .irq       (irq),
        .drq_n     (drq_n),
        .dack_n    (dack_n),
        .done_n    (done_n),
        .mem_addr  (mem_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_cs2_n (mem_cs2_n),
        .mem_rw    (mem_rw),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    typedef struct {
        logic [127:0] ev;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;

    function automatic logic [127:0] pack_ev(int c, logic [27:0] a, logic rw, logic cs,
                                             logic cs2, logic dk, logic dn, logic [31:0] wd);
        return {31'd0, c, a, rw, cs, cs2, dk, dn, wd};
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (!mem_cs_n || !mem_cs2_n || !dack_n || !done_n)) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected bus cycle",
                      pack_ev(cyc, mem_addr, mem_rw, mem_cs_n, mem_cs2_n, dack_n, done_n, mem_wdata),
                      128'd0);
            end else begin
                mon_e = exp_q.pop_front();
                check(mon_e.tag,
                      pack_ev(cyc, mem_addr, mem_rw, mem_cs_n, mem_cs2_n, dack_n, done_n, mem_wdata),
                      mon_e.ev);
            end
        end
    end

    task automatic cfg_write(logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(logic [1:0] s, logic [31:0] expv, string tag);
        @(negedge clk);
        cfg_sel = s;
        #1;
        check(tag, {96'd0, cfg_rdata}, {96'd0, expv});
    endtask

    // driver: raise a request, queue the bus cycles it must cause
    task automatic word(bit m2m, logic [27:0] src, logic [27:0] dst, bit tx, bit last,
                        int hold, string tag);
        int k;
        @(negedge clk);
        drq_n = 1'b0;
        k = cyc;
        if (!m2m) begin
            exp_q.push_back('{pack_ev(k + 3, src, tx, 1'b0, 1'b1, 1'b0, !last, 32'd0),
                              {tag, " R1 R3 direct cycle"}});
        end else begin
            exp_q.push_back('{pack_ev(k + 3, src, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'd0),
                              {tag, " R2 R3 buffered read"}});
            exp_q.push_back('{pack_ev(k + 4, dst, 1'b0, 1'b1, 1'b0, 1'b0, !last, memf(src)),
                              {tag, " R2 R11 buffered write"}});
        end
        while (dack_n !== 1'b0) @(negedge clk);
        repeat (hold) @(negedge clk);
        drq_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        @(negedge clk);
        check("R12 strobes after reset", {123'd0, dack_n, done_n, mem_cs_n, mem_cs2_n, irq},
              {123'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0});
        for (int r = 0; r < 4; r++) cfg_check(2'(r), 32'd0, "R12 register reset value");

        // direct transmit, three words; lock checked mid-block
        cfg_write(2'd1, 32'h000_1000);
        cfg_write(2'd3, 32'd3);
        cfg_write(2'd0, 32'h5);
        word(1'b0, 28'h000_1000, 28'h0, 1'b1, 1'b0, 0, "R5 tx word1");
        cfg_write(2'd1, 32'h000_FFF0);
        cfg_write(2'd3, 32'd9);
        cfg_write(2'd0, 32'h2);
        cfg_check(2'd1, 32'h000_1004, "R9 R6 source locked and stepped");
        cfg_check(2'd3, 32'd2, "R9 R6 count locked and stepped");
        cfg_check(2'd0, 32'h5, "R9 control fields locked");
        word(1'b0, 28'h000_1004, 28'h0, 1'b1, 1'b0, 0, "R5 tx word2");
        word(1'b0, 28'h000_1008, 28'h0, 1'b1, 1'b1, 0, "R5 tx last word");
        cfg_check(2'd0, 32'hC, "R7 enable cleared irq set");
        cfg_check(2'd3, 32'd0, "R6 count at zero");
        cfg_check(2'd1, 32'h000_100C, "R6 source after block");
        check("R7 irq output", {127'd0, irq}, {127'd0, 1'b1});

        // R7: request after completion runs nothing
        @(negedge clk); drq_n = 1'b0;
        repeat (10) @(negedge clk);
        drq_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8 sticky interrupt, write-one-to-clear
        cfg_write(2'd0, 32'h0);
        check("R8 irq kept without clear bit", {127'd0, irq}, {127'd0, 1'b1});
        cfg_write(2'd0, 32'h8);
        check("R8 irq cleared by bit 3", {127'd0, irq}, {127'd0, 1'b0});

        // direct receive, long-held request
        cfg_write(2'd1, 32'h0AB_CDE0);
        cfg_write(2'd3, 32'd2);
        cfg_write(2'd0, 32'h1);
        word(1'b0, 28'h0AB_CDE0, 28'h0, 1'b0, 1'b0, 10, "R4 rx held request");
        word(1'b0, 28'h0AB_CDE4, 28'h0, 1'b0, 1'b1, 0, "R5 rx last word");
        cfg_check(2'd1, 32'h0AB_CDE8, "R6 rx source after block");
        cfg_write(2'd0, 32'h8);

        // buffered, two words
        cfg_write(2'd1, 32'h000_2000);
        cfg_write(2'd2, 32'h000_3000);
        cfg_write(2'd3, 32'd2);
        cfg_write(2'd0, 32'h3);
        word(1'b1, 28'h000_2000, 28'h000_3000, 1'b0, 1'b0, 0, "R11 m2m word1");
        word(1'b1, 28'h000_2004, 28'h000_3004, 1'b0, 1'b1, 0, "R5 m2m last word");
        cfg_check(2'd1, 32'h000_2008, "R6 m2m source after block");
        cfg_check(2'd2, 32'h000_3008, "R6 m2m destination after block");
        cfg_check(2'd0, 32'hA, "R7 m2m enable cleared irq set");
        cfg_write(2'd0, 32'h8);

        // R10 zero count
        cfg_write(2'd3, 32'd0);
        cfg_write(2'd0, 32'h1);
        cfg_check(2'd0, 32'h8, "R10 zero count completes at once");
        @(negedge clk); drq_n = 1'b0;
        repeat (8) @(negedge clk);
        drq_n = 1'b1;
        repeat (4) @(negedge clk);

        check("R1 R2 all expected bus cycles seen", 128'(exp_q.size()), 128'd0);
        finish_run();
    end

endmodule